// File: doc/BRIEF.md
# SPI FIFO Watermark and Error Unit

This block sits between the register side of an SPI port and its serial shifter. It stores traffic in both directions, eight bytes per direction. Software pushes bytes for transmission and pops received bytes. The shifter pops bytes to send and pushes bytes it has received. The unit reports occupancy through four status bits, with a near-empty level for transmit and a near-full level for receive, each chosen from two fractions of the depth. A control bit drops both directions to a one-byte buffer.

Faults are kept in a four-bit error field, read out in bits 7:4 of an 8-bit read word. The error bits record an overflow (a push into a full direction, with the byte dropped) and an underrun (a pop from an empty direction, which returns zero). A read clears every bit that was set when it was sampled. Four interrupt sources latch on the rising edge of their condition. Software clears them with a write-1-to-clear port, which works only while a clear-enable bit is held. When a direction's DMA request is enabled, that direction's interrupt line is held low.

Each direction is a lane built around a three-state occupancy machine with states LN_EMPTY, LN_PARTIAL and LN_FULL. The transitions are:
- take-first: a push in LN_EMPTY moves to LN_PARTIAL, or straight to LN_FULL when the capacity is one.
- fill: a push without a pop in LN_PARTIAL that reaches capacity moves to LN_FULL.
- drain: a pop without a push in LN_PARTIAL at level one moves to LN_EMPTY.
- release: a pop in LN_FULL moves to LN_PARTIAL, or to LN_EMPTY at level one.
- hold: a push and a pop in the same cycle keep the current state.

Top module: `spi_fifo_wm_unit`

## Requirements
- R1: After reset, status is 4'b0101, the error field is zero, no interrupt source is latched, and both interrupt lines are low. Status bits: bit 0 rx empty, bit 1 tx full, bit 2 tx near-empty, bit 3 rx near-full.
- R2: With FIFO mode on, each direction holds eight bytes and returns them in push order. Tx full (status bit 1) rises after the eighth push.
- R3: With FIFO mode off, each direction holds a single byte and reports full after one push.
- R4: Tx near-empty is set while the tx level is at most 2 with watermark select 0, or at most 4 with select 1.
- R5: Rx near-full is set while the rx level is at least 6 with watermark select 0, or at least 4 with select 1.
- R6: A push into a full direction drops the byte. It sets rx overflow (read bit 4) for receive, or tx overflow (read bit 5) for transmit.
- R7: A pop from an empty direction returns zero. It sets rx error (read bit 6) for the host pop, or tx error (read bit 7) for the shifter pop.
- R8: A read strobe clears the error bits that were set when it was sampled. An error raised in that same cycle remains set afterwards.
- R9: Interrupt sources latch one cycle after their condition rises. Source bit 0 is rx full, bit 1 tx empty, bit 2 rx near-full and bit 3 tx near-empty.
- R10: A clear write removes the sources selected by its mask only while clear-enable is 1. With clear-enable at 0, a clear write has no effect.
- R11: With tx DMA enabled, irq_tx stays low and tx_dma_req follows tx near-empty. With rx DMA enabled, irq_rx stays low and rx_dma_req follows rx not-empty.
- R12: irq_rx is source 0 OR source 2. irq_tx is source 1 OR source 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fifo_en | input | 1 | 1 = eight-byte FIFO, 0 = one-byte buffer |
| cfg_tx_mark | input | 1 | Tx near-empty select: 0 quarter, 1 half |
| cfg_rx_mark | input | 1 | Rx near-full select: 0 three quarters, 1 half |
| cfg_clr_en | input | 1 | Enables write-1-to-clear |
| cfg_tx_dma_en | input | 1 | Tx DMA request enable |
| cfg_rx_dma_en | input | 1 | Rx DMA request enable |
| tx_push | input | 1 | Host pushes a byte for transmit |
| tx_push_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Shifter takes the next transmit byte |
| tx_pop_data | output | 8 | Head of transmit FIFO, zero when empty |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes the next received byte |
| rx_pop_data | output | 8 | Head of receive FIFO, zero when empty |
| status | output | 4 | Occupancy status bits |
| err_rd | input | 1 | Read strobe for the error word |
| err_rd_data | output | 8 | Error word, errors in bits 7:4 |
| irq_clr_wr | input | 1 | Write-1-to-clear strobe |
| irq_clr_mask | input | 4 | Sources to clear |
| irq_src | output | 4 | Latched interrupt sources |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The hardest case to reach is a clear-on-read in the same cycle as a new fault. Only a read that coincides with a push or pop shows whether the clear masks off the old bits alone or wipes the fresh event too. The stimulus first leaves a tx error pending by popping the empty transmit side. It then strobes the read together with a pop of the empty receive side and expects the word to change from 8'h80 to 8'h40. The edge-triggered sources need the same kind of set-up. Their conditions are reached by filling or draining a lane across a watermark, and all sources are cleared beforehand so that only the intended edges are latched.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [1:0] {
        LN_EMPTY   = 2'd0,
        LN_PARTIAL = 2'd1,
        LN_FULL    = 2'd2
    } lane_state_e;

    // status bit positions
    localparam int ST_RX_EMPTY      = 0;
    localparam int ST_TX_FULL       = 1;
    localparam int ST_TX_NEAR_EMPTY = 2;
    localparam int ST_RX_NEAR_FULL  = 3;

    // interrupt source positions
    localparam int SRC_RX_FULL       = 0;
    localparam int SRC_TX_EMPTY      = 1;
    localparam int SRC_RX_NEAR_FULL  = 2;
    localparam int SRC_TX_NEAR_EMPTY = 3;

    // error field positions (placed at 7:4 of the read word)
    localparam int ERR_RX_OVF = 0;
    localparam int ERR_TX_OVF = 1;
    localparam int ERR_RX_UNF = 2;
    localparam int ERR_TX_UNF = 3;

    // source conditions that are true out of reset (tx empty, tx near-empty)
    localparam logic [3:0] SRC_COND_RESET = 4'b1010;

endpackage

// File: rtl/spi_fifo_lane.sv
module spi_fifo_lane
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         single_buf,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         is_empty,
    output logic                         is_full,
    output logic                         ovf_evt,
    output logic                         unf_evt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    lane_state_e     state_q, state_d;
    logic [W-1:0]    mem_q [DEPTH];
    logic [AW-1:0]   wr_q, rd_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   cap;
    logic            take, give;

    // accepted operations: judged on the state before the edge
    always_comb begin
        cap  = single_buf ? ONE : FULL_LVL;
        take = push && (state_q != LN_FULL);
        give = pop  && (state_q != LN_EMPTY);
    end

    // occupancy machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_EMPTY: begin
                if (take) begin
                    state_d = (cap == ONE) ? LN_FULL : LN_PARTIAL;      // take-first
                end
            end
            LN_PARTIAL: begin
                if (take && !give && (cnt_q + ONE >= cap)) begin
                    state_d = LN_FULL;                                   // fill
                end else if (give && !take && (cnt_q == ONE)) begin
                    state_d = LN_EMPTY;                                  // drain
                end
            end
            LN_FULL: begin
                if (give) begin
                    state_d = (cnt_q == ONE) ? LN_EMPTY : LN_PARTIAL;   // release
                end
            end
            default: state_d = LN_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // pointers and level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (take) begin
                wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
            end
            if (give) begin
                rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
            end
            unique case ({take, give})
                2'b10:   cnt_q <= cnt_q + ONE;
                2'b01:   cnt_q <= cnt_q - ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // storage
    always_ff @(posedge clk) begin
        if (take) begin
            mem_q[wr_q] <= push_data;
        end
    end

    // outputs
    always_comb begin
        is_empty = (state_q == LN_EMPTY);
        is_full  = (state_q == LN_FULL);
        level    = cnt_q;
        pop_data = is_empty ? '0 : mem_q[rd_q];
        ovf_evt  = push && is_full;
        unf_evt  = pop && is_empty;
    end

endmodule

// File: rtl/spi_fifo_marks.sv
module spi_fifo_marks #(
    parameter int DEPTH = 8
) (
    input  logic                       single_buf,
    input  logic                       tx_sel,
    input  logic                       rx_sel,
    input  logic [$clog2(DEPTH+1)-1:0] tx_level,
    input  logic [$clog2(DEPTH+1)-1:0] rx_level,
    input  logic                       tx_empty,
    input  logic                       rx_full,
    output logic                       tx_near_empty,
    output logic                       rx_near_full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] QUARTER  = CW'(DEPTH / 4);
    localparam logic [CW-1:0] HALF     = CW'(DEPTH / 2);
    localparam logic [CW-1:0] THREE_QT = CW'((3 * DEPTH) / 4);

    logic [CW-1:0] tx_lim, rx_lim;

    always_comb begin
        tx_lim = tx_sel ? HALF : QUARTER;
        rx_lim = rx_sel ? HALF : THREE_QT;
        if (single_buf) begin
            tx_near_empty = tx_empty;
            rx_near_full  = rx_full;
        end else begin
            tx_near_empty = (tx_level <= tx_lim);
            rx_near_full  = (rx_level >= rx_lim);
        end
    end

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
    import spi_fifo_pkg::*;
#(
    parameter int              NSRC     = 4,
    parameter int              NERR     = 4,
    parameter logic [NSRC-1:0] COND_RST = SRC_COND_RESET
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond,
    input  logic            clr_en,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NERR-1:0] err_evt,
    input  logic            err_rd,
    output logic [NSRC-1:0] src,
    output logic [NERR-1:0] err
);
    logic            clr_go;
    logic [NERR-1:0] err_q;

    assign clr_go = clr_en && clr_wr;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic cond_q;
        logic hit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cond_q <= COND_RST[i];
                hit_q  <= 1'b0;
            end else begin
                cond_q <= cond[i];
                if (cond[i] && !cond_q) begin
                    hit_q <= 1'b1;
                end else if (clr_go && clr_mask[i]) begin
                    hit_q <= 1'b0;
                end
            end
        end
        assign src[i] = hit_q;
    end

    // clear-on-read keeps only events that arrive with the read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (err_rd) begin
            err_q <= err_evt;
        end else begin
            err_q <= err_q | err_evt;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/spi_fifo_wm_unit.sv
module spi_fifo_wm_unit
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_fifo_en,
    input  logic         cfg_tx_mark,
    input  logic         cfg_rx_mark,
    input  logic         cfg_clr_en,
    input  logic         cfg_tx_dma_en,
    input  logic         cfg_rx_dma_en,
    input  logic         tx_push,
    input  logic [W-1:0] tx_push_data,
    input  logic         tx_pop,
    output logic [W-1:0] tx_pop_data,
    input  logic         rx_push,
    input  logic [W-1:0] rx_push_data,
    input  logic         rx_pop,
    output logic [W-1:0] rx_pop_data,
    output logic [3:0]   status,
    input  logic         err_rd,
    output logic [7:0]   err_rd_data,
    input  logic         irq_clr_wr,
    input  logic [3:0]   irq_clr_mask,
    output logic [3:0]   irq_src,
    output logic         irq_rx,
    output logic         irq_tx,
    output logic         tx_dma_req,
    output logic         rx_dma_req
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          single_buf;
    logic [CW-1:0] tx_level, rx_level;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic          tx_ne, rx_nf;
    logic [3:0]    cond, err_evt, err;

    assign single_buf = !cfg_fifo_en;

    spi_fifo_lane #(.DEPTH(DEPTH), .W(W)) u_tx_lane (
        .clk(clk), .rst_n(rst_n), .single_buf(single_buf),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .pop_data(tx_pop_data), .level(tx_level),
        .is_empty(tx_empty), .is_full(tx_full),
        .ovf_evt(tx_ovf), .unf_evt(tx_unf)
    );

    spi_fifo_lane #(.DEPTH(DEPTH), .W(W)) u_rx_lane (
        .clk(clk), .rst_n(rst_n), .single_buf(single_buf),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .pop_data(rx_pop_data), .level(rx_level),
        .is_empty(rx_empty), .is_full(rx_full),
        .ovf_evt(rx_ovf), .unf_evt(rx_unf)
    );

    spi_fifo_marks #(.DEPTH(DEPTH)) u_marks (
        .single_buf(single_buf), .tx_sel(cfg_tx_mark), .rx_sel(cfg_rx_mark),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_empty(tx_empty), .rx_full(rx_full),
        .tx_near_empty(tx_ne), .rx_near_full(rx_nf)
    );

    spi_fifo_flags #(.NSRC(4), .NERR(4), .COND_RST(SRC_COND_RESET)) u_flags (
        .clk(clk), .rst_n(rst_n), .cond(cond),
        .clr_en(cfg_clr_en), .clr_wr(irq_clr_wr), .clr_mask(irq_clr_mask),
        .err_evt(err_evt), .err_rd(err_rd),
        .src(irq_src), .err(err)
    );

    // output process
    always_comb begin
        cond                    = '0;
        cond[SRC_RX_FULL]       = rx_full;
        cond[SRC_TX_EMPTY]      = tx_empty;
        cond[SRC_RX_NEAR_FULL]  = rx_nf;
        cond[SRC_TX_NEAR_EMPTY] = tx_ne;

        err_evt             = '0;
        err_evt[ERR_RX_OVF] = rx_ovf;
        err_evt[ERR_TX_OVF] = tx_ovf;
        err_evt[ERR_RX_UNF] = rx_unf;
        err_evt[ERR_TX_UNF] = tx_unf;

        status                   = '0;
        status[ST_RX_EMPTY]      = rx_empty;
        status[ST_TX_FULL]       = tx_full;
        status[ST_TX_NEAR_EMPTY] = tx_ne;
        status[ST_RX_NEAR_FULL]  = rx_nf;

        err_rd_data = {err, 4'b0000};

        irq_rx     = (irq_src[SRC_RX_FULL] | irq_src[SRC_RX_NEAR_FULL]) & !cfg_rx_dma_en;
        irq_tx     = (irq_src[SRC_TX_EMPTY] | irq_src[SRC_TX_NEAR_EMPTY]) & !cfg_tx_dma_en;
        tx_dma_req = cfg_tx_dma_en & tx_ne;
        rx_dma_req = cfg_rx_dma_en & !rx_empty;
    end

endmodule

// File: rtl/spi_fifo_wm_chk.sv
module spi_fifo_wm_chk #(
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_fifo_en,
    input logic                       cfg_tx_mark,
    input logic                       cfg_clr_en,
    input logic                       tx_push,
    input logic                       tx_pop,
    input logic                       rx_push,
    input logic                       rx_pop,
    input logic                       err_rd,
    input logic [3:0]                 status,
    input logic [7:0]                 err_rd_data,
    input logic [3:0]                 irq_src,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic                       rx_full
);
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= DEPTH);

    a_r3_single_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && tx_level != 0) |-> status[1]);

    a_r4_quarter_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && !cfg_tx_mark && tx_level <= DEPTH / 4) |-> status[2]);

    a_r6_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && status[1]) |=> err_rd_data[5]);

    a_r6_rx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> err_rd_data[4]);

    a_r7_tx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_level == 0) |=> err_rd_data[7]);

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd && !tx_push && !tx_pop && !rx_push && !rx_pop) |=> (err_rd_data[7:4] == 4'b0000));

    a_r10_clear_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_clr_en |=> ((irq_src & $past(irq_src)) == $past(irq_src)));

endmodule

bind spi_fifo_wm_unit spi_fifo_wm_chk #(.DEPTH(DEPTH)) u_wm_chk (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_tx_mark(cfg_tx_mark),
    .cfg_clr_en(cfg_clr_en), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_push(rx_push), .rx_pop(rx_pop), .err_rd(err_rd),
    .status(status), .err_rd_data(err_rd_data), .irq_src(irq_src),
    .tx_level(tx_level), .rx_full(rx_full)
);

// File: tb/spi_fifo_wm_unit_bench.sv
module spi_fifo_wm_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_fifo_en = 1'b1, cfg_tx_mark = 1'b0, cfg_rx_mark = 1'b0;
    logic       cfg_clr_en = 1'b0, cfg_tx_dma_en = 1'b0, cfg_rx_dma_en = 1'b0;
    logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] tx_push_data = '0, rx_push_data = '0;
    logic [7:0] tx_pop_data, rx_pop_data;
    logic [3:0] status, irq_src;
    logic       err_rd = 1'b0, irq_clr_wr = 1'b0;
    logic [3:0] irq_clr_mask = '0;
    logic [7:0] err_rd_data;
    logic       irq_rx, irq_tx, tx_dma_req, rx_dma_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] q_tx[$];
    logic [7:0] q_rx[$];

    always #2 clk = ~clk;

    spi_fifo_wm_unit u_spi_fifo_wm_unit (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_tx_mark(cfg_tx_mark),
        .cfg_rx_mark(cfg_rx_mark), .cfg_clr_en(cfg_clr_en), .cfg_tx_dma_en(cfg_tx_dma_en),
        .cfg_rx_dma_en(cfg_rx_dma_en), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_push(rx_push),
        .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .status(status), .err_rd(err_rd), .err_rd_data(err_rd_data),
        .irq_clr_wr(irq_clr_wr), .irq_clr_mask(irq_clr_mask), .irq_src(irq_src),
        .irq_rx(irq_rx), .irq_tx(irq_tx), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, req, act, exp);
    endtask

    // driver tasks: start and end at a falling edge
    task automatic host_tx(input logic [7:0] d, input bit keep);
        tx_push = 1'b1; tx_push_data = d;
        if (keep) q_tx.push_back(d);
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic shift_rx(input logic [7:0] d, input bit keep);
        rx_push = 1'b1; rx_push_data = d;
        if (keep) q_rx.push_back(d);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // monitors: compare popped bytes with the scoreboard queues
    task automatic shift_tx_drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            logic [7:0] exp;
            got = tx_pop_data;
            exp = (q_tx.size() != 0) ? q_tx.pop_front() : 8'h00;
            eq(req, {24'h0, got}, {24'h0, exp});
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
    endtask

    task automatic host_rx_drain(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] got;
            logic [7:0] exp;
            got = rx_pop_data;
            exp = (q_rx.size() != 0) ? q_rx.pop_front() : 8'h00;
            eq(req, {24'h0, got}, {24'h0, exp});
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    task automatic read_err(input string req, input logic [7:0] exp);
        eq(req, {24'h0, err_rd_data}, {24'h0, exp});
        err_rd = 1'b1;
        @(negedge clk);
        err_rd = 1'b0;
    endtask

    task automatic clear_src(input logic [3:0] m);
        irq_clr_wr = 1'b1; irq_clr_mask = m;
        @(negedge clk);
        irq_clr_wr = 1'b0; irq_clr_mask = '0;
    endtask

    initial begin
        #400000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        eq("R1 status", {28'h0, status}, 32'h5);
        eq("R1 err", {24'h0, err_rd_data}, 32'h0);
        eq("R1 src", {28'h0, irq_src}, 32'h0);
        eq("R1 irq", {30'h0, irq_rx, irq_tx}, 32'h0);

        // R2/R4 fill transmit with quarter mark
        for (int i = 1; i <= 8; i++) begin
            host_tx(8'h10 + 8'(i), 1'b1);
            eq("R4 tx near-empty quarter", {31'h0, status[2]}, (i <= 2) ? 32'h1 : 32'h0);
        end
        eq("R2 tx full after eight", {31'h0, status[1]}, 32'h1);
        // R6 push into full transmit is dropped
        host_tx(8'hEE, 1'b0);
        read_err("R6 tx overflow", 8'h20);
        eq("R8 err cleared after read", {24'h0, err_rd_data}, 32'h0);
        shift_tx_drain(8, "R2 tx order");
        @(negedge clk);
        eq("R9 tx sources latched", {28'h0, irq_src}, 32'hA);
        eq("R12 irq_tx", {31'h0, irq_tx}, 32'h1);
        // R7 underrun on transmit
        eq("R7 tx empty data", {24'h0, tx_pop_data}, 32'h0);
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        read_err("R7 tx error bit", 8'h80);

        // R10 clear ignored while disabled
        clear_src(4'b1010);
        eq("R10 clear ignored", {28'h0, irq_src}, 32'hA);
        cfg_clr_en = 1'b1;
        clear_src(4'b0010);
        eq("R10 clear applied", {28'h0, irq_src}, 32'h8);

        // R11 tx DMA suppresses irq_tx
        cfg_tx_dma_en = 1'b1;
        @(negedge clk);
        eq("R11 irq_tx suppressed", {31'h0, irq_tx}, 32'h0);
        eq("R11 tx dma req", {31'h0, tx_dma_req}, 32'h1);
        cfg_tx_dma_en = 1'b0;
        clear_src(4'hF);

        // R4 half mark
        cfg_tx_mark = 1'b1;
        @(negedge clk);
        for (int i = 1; i <= 5; i++) host_tx(8'h40 + 8'(i), 1'b1);
        eq("R4 tx above half", {31'h0, status[2]}, 32'h0);
        shift_tx_drain(1, "R2 tx order half");
        eq("R4 tx at half", {31'h0, status[2]}, 32'h1);
        shift_tx_drain(4, "R2 tx order half");
        @(negedge clk);
        clear_src(4'hF);
        eq("R10 all cleared", {28'h0, irq_src}, 32'h0);

        // R5/R6 receive with three-quarter mark
        for (int i = 1; i <= 8; i++) begin
            shift_rx(8'hA0 + 8'(i), 1'b1);
            eq("R5 rx near-full 3/4", {31'h0, status[3]}, (i >= 6) ? 32'h1 : 32'h0);
        end
        eq("R2 rx not empty", {31'h0, status[0]}, 32'h0);
        shift_rx(8'h55, 1'b0);
        read_err("R6 rx overflow", 8'h10);
        eq("R9 rx sources latched", {28'h0, irq_src}, 32'h5);
        eq("R12 irq_rx", {31'h0, irq_rx}, 32'h1);
        cfg_rx_dma_en = 1'b1;
        @(negedge clk);
        eq("R11 irq_rx suppressed", {31'h0, irq_rx}, 32'h0);
        eq("R11 rx dma req", {31'h0, rx_dma_req}, 32'h1);
        cfg_rx_dma_en = 1'b0;
        host_rx_drain(8, "R2 rx order");
        eq("R7 rx empty data", {24'h0, rx_pop_data}, 32'h0);
        rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0;
        read_err("R7 rx error bit", 8'h40);

        // R5 half mark
        cfg_rx_mark = 1'b1;
        for (int i = 1; i <= 3; i++) shift_rx(8'hC0 + 8'(i), 1'b1);
        eq("R5 rx below half", {31'h0, status[3]}, 32'h0);
        shift_rx(8'hC4, 1'b1);
        eq("R5 rx at half", {31'h0, status[3]}, 32'h1);
        host_rx_drain(4, "R2 rx order half");

        // R8 read coincides with a new fault
        tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        eq("R8 before read", {24'h0, err_rd_data}, 32'h80);
        err_rd = 1'b1; rx_pop = 1'b1;
        @(negedge clk);
        err_rd = 1'b0; rx_pop = 1'b0;
        eq("R8 new event kept", {24'h0, err_rd_data}, 32'h40);
        read_err("R8 final", 8'h40);

        // R3 single-buffer mode
        cfg_fifo_en = 1'b0;
        @(negedge clk);
        host_tx(8'h3C, 1'b1);
        eq("R3 single full", {31'h0, status[1]}, 32'h1);
        eq("R3 single not near-empty", {31'h0, status[2]}, 32'h0);
        host_tx(8'h99, 1'b0);
        read_err("R3 single overflow", 8'h20);
        shift_tx_drain(1, "R3 single data");
        eq("R3 single empty again", {31'h0, status[1]}, 32'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule